// File: doc/BRIEF.md
# Pattern and Edge Trigger Capture Unit

This block records a multi-channel sample bus into a circular buffer, one sample per clock, from the moment it is armed. Every stored sample is also tested against a trigger condition. The condition is set by a mode select and takes one of two forms:

- **Level match.** Each channel is required high, required low, or ignored.
- **Transition.** A rising or falling change on one chosen channel.

Once the condition is met, the block keeps recording for a programmable number of further samples and then halts. The buffer then holds history from both before and after the trigger point. Recording runs all the time and only stops at the trigger, which is the opposite of an instrument that starts acquiring at its trigger.

After the halt, the block raises a done flag and exposes two things:

- the buffer slot where the triggering sample landed;
- a read port whose index counts from the oldest stored sample, so reading indices upward walks the record in time order.

The post-trigger delay lets the trigger be placed after the response of a device whose outputs lag its inputs.

By default, a trigger is only honoured once the buffer has filled completely after arming. This guarantees a full pre-trigger history. An "immediate" input removes that wait.

The controller is a five-state machine:

| State | Behaviour |
|---|---|
| IDLE | Entered at reset; nothing is stored. |
| FILL | Stores samples and ignores the trigger until the buffer is full. |
| WATCH | Stores samples and tests each one. |
| POST | Counts down the post-trigger delay while storing. |
| HALT | Done; storage is frozen. |

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| start | any state | FILL | arm with immediate low |
| start_now | any state | WATCH | arm with immediate high |
| full | FILL | WATCH | the last empty slot is written |
| fire_late | WATCH | POST | trigger hit and delay non-zero |
| fire_stop | WATCH | HALT | trigger hit and delay zero |
| expire | POST | HALT | the final delayed sample is written |

Top module: `trig_capture`

## Requirements
- R1: After reset, done is 0 and trig_slot is 0, and nothing is stored until arm is seen.
- R2: With mode_edge=0, a sample hits when, for every channel i whose care bit is 1, data bit i equals pat_level bit i; channels with care bit 0 have no influence. For example, pat_level 0x55 with care 0xFF requires even channels high and odd channels low.
- R3: With mode_edge=1, a sample hits when bit edge_ch of the previous stored sample and of the current sample go 0 to 1 (edge_fall=0) or 1 to 0 (edge_fall=1). The first sample stored after arm has no predecessor and never hits.
- R4: Samples are numbered k=0,1,... from the first clock after the arm clock. With arm_now=0, hits on samples k < 2**AW are ignored. With arm_now=1 at the arm clock, any sample may trigger.
- R5: If the trigger sample is k=t and post_len=P (sampled at the trigger), exactly samples 0..t+P are stored. done is 1 from the clock after sample t+P is taken and 0 before.
- R6: When done, trig_slot equals t mod 2**AW, the physical slot of the trigger sample.
- R7: When done and n=t+P+1 samples were stored, rd_data for rd_idx=j equals sample n-2**AW+j, for every j where that index is non-negative.
- R8: arm restarts capture from any state, including mid-capture or HALT. done is 0 on the clock after arm, and the sample count restarts at 0.
- R9: While done and arm is low, changes on the sample bus alter neither rd_data nor trig_slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge while capturing |
| rst_n | input | 1 | Synchronous active-low reset |
| samp | input | CH | Sample bus |
| pat_level | input | CH | Required level per channel in level-match mode |
| pat_care | input | CH | 1 = channel compared, 0 = don't care |
| edge_ch | input | $clog2(CH) | Channel watched in transition mode |
| edge_fall | input | 1 | 0 = rising, 1 = falling transition |
| mode_edge | input | 1 | 0 = level match, 1 = transition |
| post_len | input | AW | Samples stored after the trigger sample |
| arm | input | 1 | Start/restart capture |
| arm_now | input | 1 | With arm: allow trigger before the buffer is full |
| done | output | 1 | Capture halted |
| trig_slot | output | AW | Buffer slot of the trigger sample |
| rd_idx | input | AW | Read index, 0 = oldest |
| rd_data | output | CH | Sample at rd_idx |

## Verification
The bench builds the block with 8 channels and a 16-entry buffer. At that size the following become affordable:

- every post-trigger delay from 0 to 15;
- every channel and both polarities in transition mode;
- a full readout of the buffer after every run.

The sample stream is an affine sequence modulo 256 with an odd step, which visits every byte value. Any level pattern is therefore reached within one period, and the bench can compute the trigger sample index arithmetically. With this small depth, immediate-trigger runs that stop before the buffer wraps are also reachable, so partially filled readouts and the fill-wait boundary at sample 16 are exercised.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WATCH,
        ST_POST,
        ST_HALT
    } cap_state_t;

endpackage

// File: rtl/trig_capture_match.sv
module trig_capture_match #(
    parameter int CH = 8,
    localparam int SW = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          wr_en,
    input  logic [CH-1:0] samp,
    input  logic [CH-1:0] pat_level,
    input  logic [CH-1:0] pat_care,
    input  logic [SW-1:0] edge_ch,
    input  logic          edge_fall,
    input  logic          mode_edge,
    output logic          hit
);

    logic [CH-1:0] prev_samp;
    logic          prev_ok;
    logic [CH-1:0] lane_ok;
    logic          level_hit;
    logic          edge_hit;
    logic          old_bit;
    logic          new_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_samp <= '0;
            prev_ok   <= 1'b0;
        end else if (restart) begin
            prev_ok   <= 1'b0;
        end else if (wr_en) begin
            prev_samp <= samp;
            prev_ok   <= 1'b1;
        end
    end

    for (genvar i = 0; i < CH; i++) begin : g_lane
        assign lane_ok[i] = !pat_care[i] || (samp[i] == pat_level[i]);
    end

    always_comb begin
        level_hit = &lane_ok;
        old_bit   = prev_samp[edge_ch];
        new_bit   = samp[edge_ch];
        if (edge_fall) begin
            edge_hit = prev_ok && old_bit && !new_bit;
        end else begin
            edge_hit = prev_ok && !old_bit && new_bit;
        end
        hit = mode_edge ? edge_hit : level_hit;
    end

endmodule

// File: rtl/trig_capture_store.sv
module trig_capture_store #(
    parameter int CH = 8,
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          wr_en,
    input  logic [CH-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [CH-1:0] rd_data,
    output logic [AW-1:0] wr_ptr
);

    logic [CH-1:0] mem [DEPTH];
    logic [AW-1:0] rd_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (restart) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !restart) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_comb begin
        rd_slot = wr_ptr + rd_idx;
        rd_data = mem[rd_slot];
    end

endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import trig_capture_pkg::*;
#(
    parameter int AW = 4,
    localparam logic [AW-1:0] LAST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          arm_now,
    input  logic          hit,
    input  logic [AW-1:0] post_len,
    output logic          wr_en,
    output logic          restart,
    output logic          take_trig,
    output logic          done
);

    cap_state_t    st;
    cap_state_t    st_nxt;
    logic [AW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        if (arm) begin
            st_nxt = arm_now ? ST_WATCH : ST_FILL;
        end else begin
            unique case (st)
                ST_IDLE:  st_nxt = ST_IDLE;
                ST_FILL:  if (cnt == LAST) st_nxt = ST_WATCH;
                ST_WATCH: if (hit) st_nxt = (post_len == '0) ? ST_HALT : ST_POST;
                ST_POST:  if (cnt == AW'(1)) st_nxt = ST_HALT;
                ST_HALT:  st_nxt = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= '0;
        end else begin
            unique case (st)
                ST_FILL:  cnt <= cnt + 1'b1;
                ST_WATCH: if (hit) cnt <= post_len;
                ST_POST:  cnt <= cnt - 1'b1;
                default:  cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        restart   = arm;
        wr_en     = !arm && (st == ST_FILL || st == ST_WATCH || st == ST_POST);
        take_trig = !arm && (st == ST_WATCH) && hit;
        done      = (st == ST_HALT);
    end

endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
    parameter int CH = 8,
    parameter int AW = 4,
    localparam int SW = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] samp,
    input  logic [CH-1:0] pat_level,
    input  logic [CH-1:0] pat_care,
    input  logic [SW-1:0] edge_ch,
    input  logic          edge_fall,
    input  logic          mode_edge,
    input  logic [AW-1:0] post_len,
    input  logic          arm,
    input  logic          arm_now,
    output logic          done,
    output logic [AW-1:0] trig_slot,
    input  logic [AW-1:0] rd_idx,
    output logic [CH-1:0] rd_data
);

    logic          wr_en;
    logic          restart;
    logic          take_trig;
    logic          hit;
    logic [AW-1:0] wr_ptr;

    trig_capture_match #(.CH(CH)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .wr_en     (wr_en),
        .samp      (samp),
        .pat_level (pat_level),
        .pat_care  (pat_care),
        .edge_ch   (edge_ch),
        .edge_fall (edge_fall),
        .mode_edge (mode_edge),
        .hit       (hit)
    );

    trig_capture_store #(.CH(CH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .wr_en   (wr_en),
        .wr_data (samp),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_ptr  (wr_ptr)
    );

    trig_capture_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .arm_now   (arm_now),
        .hit       (hit),
        .post_len  (post_len),
        .wr_en     (wr_en),
        .restart   (restart),
        .take_trig (take_trig),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_slot <= '0;
        end else if (take_trig) begin
            trig_slot <= wr_ptr;
        end
    end

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
    parameter int CH = 8,
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          arm_now,
    input logic          done,
    input logic [AW-1:0] trig_slot,
    input logic [AW-1:0] rd_idx,
    input logic [CH-1:0] rd_data
);

    int   since_arm;
    logic now_lat;
    logic ever_armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_arm  <= 0;
            now_lat    <= 1'b0;
            ever_armed <= 1'b0;
        end else if (arm) begin
            since_arm  <= 0;
            now_lat    <= arm_now;
            ever_armed <= 1'b1;
        end else if (since_arm < DEPTH + 4) begin
            since_arm  <= since_arm + 1;
        end
    end

    AST_ARM_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !done); // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done); // R5
    AST_SLOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> $stable(trig_slot)); // R9
    AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done) && !$past(arm) && $stable(rd_idx)) |-> $stable(rd_data)); // R9
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ever_armed && (now_lat || since_arm >= DEPTH + 1))); // R4

    always_comb begin
        if (rst_n && !ever_armed) begin
            AST_IDLE_AT_RESET: assert (!done); // R1
        end
    end

endmodule

bind trig_capture trig_capture_chk #(.CH(CH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .arm_now   (arm_now),
    .done      (done),
    .trig_slot (trig_slot),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
);

// File: tb/trig_capture_test.sv
`timescale 1ns/1ps
module trig_capture_test;

    localparam int CH    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CH-1:0] samp = '0;
    logic [CH-1:0] pat_level = '0;
    logic [CH-1:0] pat_care = '0;
    logic [2:0]    edge_ch = '0;
    logic          edge_fall = 1'b0;
    logic          mode_edge = 1'b0;
    logic [AW-1:0] post_len = '0;
    logic          arm = 1'b0;
    logic          arm_now = 1'b0;
    logic          done;
    logic [AW-1:0] trig_slot;
    logic [AW-1:0] rd_idx = '0;
    logic [CH-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit over   = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_capture #(.CH(CH), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .samp(samp), .pat_level(pat_level),
        .pat_care(pat_care), .edge_ch(edge_ch), .edge_fall(edge_fall),
        .mode_edge(mode_edge), .post_len(post_len), .arm(arm),
        .arm_now(arm_now), .done(done), .trig_slot(trig_slot),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int k, input int seed);
        return 8'((k * 37 + seed) & 255);
    endfunction

    // expected trigger sample index from R2, R3, R4
    function automatic int find_trig(input bit me, input logic [7:0] lv,
                                     input logic [7:0] cr, input int ch,
                                     input bit fall, input bit now, input int seed);
        int kmin;
        kmin = now ? 0 : DEPTH;
        if (me && kmin < 1) kmin = 1;
        for (int k = kmin; k < 600; k++) begin
            if (!me) begin
                if (((gen(k, seed) ^ lv) & cr) == 8'h00) return k;
            end else begin
                bit a, b;
                a = gen(k - 1, seed)[ch];
                b = gen(k, seed)[ch];
                if (!fall && !a && b) return k;
                if (fall && a && !b) return k;
            end
        end
        return -1;
    endfunction

    task automatic run(input bit me, input logic [7:0] lv, input logic [7:0] cr,
                       input int ch, input bit fall, input int post,
                       input bit now, input int seed);
        int t, n, k;
        t = find_trig(me, lv, cr, ch, fall, now, seed);
        if (t < 0) return;
        n = t + post + 1;
        @(negedge clk);
        mode_edge = me; pat_level = lv; pat_care = cr; edge_ch = 3'(ch);
        edge_fall = fall; post_len = AW'(post); arm_now = now; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0; arm_now = 1'b0;
        chk(done == 1'b0, "R8 done cleared after arm", int'(done), 0);
        k = 0;
        while (!done && k < 620) begin
            samp = gen(k, seed);
            @(negedge clk);
            k++;
        end
        chk(k == n, "R5 samples stored before done", k, n);
        chk(trig_slot == AW'(t % DEPTH), "R6 trigger slot", int'(trig_slot), t % DEPTH);
        for (int j = 0; j < DEPTH; j++) begin
            int src;
            src = n - DEPTH + j;
            if (src >= 0) begin
                rd_idx = AW'(j);
                #0.5;
                chk(rd_data == gen(src, seed), me ? "R7 R3 readout" : "R7 R2 readout",
                    int'(rd_data), int'(gen(src, seed)));
            end
        end
        // R9: bus keeps moving while halted
        for (int q = 0; q < 3; q++) begin
            samp = gen(k + 50 + q, seed + 3);
            @(negedge clk);
        end
        rd_idx = AW'(DEPTH - 1);
        #0.5;
        chk(rd_data == gen(n - 1, seed), "R9 buffer frozen", int'(rd_data), int'(gen(n - 1, seed)));
        chk(trig_slot == AW'(t % DEPTH), "R9 slot frozen", int'(trig_slot), t % DEPTH);
        chk(done == 1'b1, "R5 done held", int'(done), 1);
    endtask

    initial begin : watchdog
        wait (cyc > 190000);
        if (!over) begin
            over = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, no activity without arm
        for (int q = 0; q < 5; q++) begin
            samp = 8'(q * 91);
            @(negedge clk);
        end
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(trig_slot == '0, "R1 slot after reset", int'(trig_slot), 0);

        // R2 level match sweep over delays and care masks
        for (int p = 0; p < DEPTH; p++) begin
            run(1'b0, 8'h55, 8'hFF, 0, 1'b0, p, 1'b0, p * 11);
            run(1'b0, 8'hA3, 8'h0F, 0, 1'b0, p, 1'b0, p * 7 + 1);
            run(1'b0, 8'h80, 8'h80, 0, 1'b0, p, 1'b0, p * 5 + 2);
            run(1'b0, 8'h00, 8'h00, 0, 1'b0, p, 1'b0, p + 9);
        end
        // R3 transition mode: every channel, both polarities
        for (int c = 0; c < CH; c++) begin
            for (int f = 0; f < 2; f++) begin
                run(1'b1, 8'h00, 8'h00, c, f[0], c % DEPTH, 1'b0, c * 13 + f);
                run(1'b1, 8'h00, 8'h00, c, f[0], 15 - c, 1'b1, c * 3 + f * 40);
            end
        end
        // R4 immediate trigger, including partially filled buffer
        for (int p = 0; p < DEPTH; p++) begin
            run(1'b0, 8'h00, 8'h00, 0, 1'b0, p, 1'b1, p * 17);
            run(1'b0, gen(3, p), 8'hFF, 0, 1'b0, p, 1'b1, p);
            run(1'b0, gen(3, p), 8'hFF, 0, 1'b0, p, 1'b0, p);
        end
        // R8 re-arm in the middle of a capture, then a normal capture
        @(negedge clk);
        pat_care = 8'h00; mode_edge = 1'b0; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        for (int q = 0; q < 7; q++) begin
            samp = 8'(q);
            @(negedge clk);
        end
        chk(done == 1'b0, "R8 mid-capture not done", int'(done), 0);
        run(1'b0, 8'h55, 8'hFF, 0, 1'b0, 4, 1'b0, 77);

        if (!over) begin
            over = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule